// File: doc/BRIEF.md
# CPU Clock Frequency Selection and Micro-Step Controller

This block turns register-level frequency requests into the settings a clock synthesizer needs: the CPU output frequency, the VCO frequency, the VCO post-divider and the feedback loop count. It supports three ways of asking for a frequency. The first picks one of 32 preset entries. The second moves linearly up or down from a preset entry in signed steps. The third sets the loop count directly. The preset index comes either from board jumper inputs or from a register field. All frequencies are integers in units of 0.001 MHz (kHz), so the 0.028 MHz loop constant (28 kHz) and the per-entry step sizes are exact.

A request is started with a one-cycle apply strobe. The block captures the inputs, works out the candidate setting and runs one shared iterative divider. It then either commits the result with a one-cycle update pulse, or rejects it when the VCO frequency falls outside the legal range. A rejected request raises an error flag and leaves the last legal setting on the outputs. While a request is being processed the block is busy, and further strobes are ignored.

Top module: `cpu_freq_sel`

## Requirements
- R1: With mode code 0, preset entry i (0..31) gives CPU = 66000 + 4000*i kHz. The divider is 4 for i < 16 and 6 otherwise. VCO = CPU * divider, and the loop count = floor(VCO / 28).
- R2: The preset index is `reg_idx_i` when `idx_from_reg_i` = 1 and `jumper_idx_i` when it is 0; the unselected source has no effect.
- R3: With mode code 1, `step_code_i` bit 7 is the sign (1 = down) and bits 6:0 are the magnitude m. CPU = preset CPU ± m * s, where s = floor(1790 / preset divider) kHz. VCO and loop count follow as in R1.
- R4: A step code with the sign bit set and magnitude 0 gives the same result as a zero step.
- R5: With mode code 2, VCO = `loop_n_i` * 28 kHz, CPU = floor(VCO / divider), and the loop-count output equals `loop_n_i`.
- R6: When `div_ovr_en_i` = 1, `div_ovr_i` replaces the preset divider in every mode. The step size s in R3 still comes from the preset divider.
- R7: Mode code 3 behaves as mode 0; the step code and loop count are ignored.
- R8: A request whose VCO is below 200000 kHz or above 1200000 kHz, or whose divider is 0, is rejected. `cfg_err_o` goes to 1, no update pulse is given and all frequency outputs keep their previous values. Both range limits are themselves legal.
- R9: An accepted request clears `cfg_err_o`, updates all four setting outputs and raises `upd_valid_o` for exactly one cycle in that same cycle. The setting outputs change at no other time.
- R10: `busy_o` rises in the cycle after an apply strobe taken while idle and falls when the request completes. An apply strobe seen while busy is ignored.
- R11: After reset, all setting outputs are 0 and `busy_o`, `upd_valid_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| apply_i | input | 1 | Start a request with the current inputs |
| mode_i | input | 2 | 0 preset, 1 micro-step, 2 direct loop count, 3 preset |
| jumper_idx_i | input | 5 | Preset index from board jumpers |
| reg_idx_i | input | 5 | Preset index from register |
| idx_from_reg_i | input | 1 | Select the register index instead of the jumpers |
| step_code_i | input | 8 | Sign (bit 7) and step magnitude (bits 6:0) |
| loop_n_i | input | 16 | Loop count for direct mode |
| div_ovr_en_i | input | 1 | Use the register divider instead of the preset divider |
| div_ovr_i | input | 4 | Register divider value |
| busy_o | output | 1 | Request in progress |
| upd_valid_o | output | 1 | One-cycle pulse when the outputs are updated |
| cfg_err_o | output | 1 | Last completed request was rejected |
| cpu_khz_o | output | 22 | CPU frequency in kHz |
| vco_khz_o | output | 22 | VCO frequency in kHz |
| vco_div_o | output | 4 | VCO divider in use |
| loop_n_o | output | 16 | Feedback loop count |

## Verification
The bench builds the block with its default parameters: 200000 to 1200000 kHz VCO limits and a 28 kHz loop constant. With these values the preset entry 21 with a divider override of 8 lands exactly on the upper limit. The same entry stepped up by one step lands just beyond it, so both sides of the range check can be reached with exact integers. The defaults also put every preset entry inside the range. This lets the bench reach rejection only through overrides, large steps or large direct loop counts, and check that rejection keeps the previous setting.

// File: rtl/cpu_freq_sel_pkg.sv
package cpu_freq_sel_pkg;

    localparam int IDX_W  = 5;
    localparam int STEP_W = 8;
    localparam int MAG_W  = STEP_W - 1;
    localparam int N_W    = 16;
    localparam int DIV_W  = 4;
    localparam int FREQ_W = 22;

    localparam int unsigned TBL_BASE_KHZ = 66000;
    localparam int unsigned TBL_INC_KHZ  = 4000;
    localparam int unsigned TBL_SPLIT    = 16;
    localparam int unsigned TBL_DIV_LO   = 4;
    localparam int unsigned TBL_DIV_HI   = 6;
    localparam int unsigned ALPHA_KHZ    = 1790;
    localparam int unsigned KHZ_PER_N    = 28;
    localparam int unsigned VCO_MIN_KHZ  = 200000;
    localparam int unsigned VCO_MAX_KHZ  = 1200000;

    typedef enum logic [1:0] {
        MODE_PRESET = 2'd0,
        MODE_STEP   = 2'd1,
        MODE_DIRECT = 2'd2,
        MODE_ALT    = 2'd3
    } fsel_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_FIN
    } fsel_state_e;

    typedef struct packed {
        logic [FREQ_W-1:0] cpu;
        logic [DIV_W-1:0]  div;
        logic [FREQ_W-1:0] step;
    } tbl_entry_t;

    typedef struct packed {
        fsel_mode_e        mode;
        logic [IDX_W-1:0]  idx;
        logic [STEP_W-1:0] step;
        logic [N_W-1:0]    n;
        logic              ovr_en;
        logic [DIV_W-1:0]  ovr_div;
    } fsel_req_t;

    typedef struct packed {
        logic [FREQ_W-1:0] cpu;
        logic [FREQ_W-1:0] vco;
        logic [DIV_W-1:0]  div;
        logic [N_W-1:0]    n;
        logic              bad;
        logic              direct;
    } fsel_res_t;

    // Preset entries are generated from a linear rule instead of stored.
    function automatic tbl_entry_t tbl_lookup(input logic [IDX_W-1:0] idx);
        tbl_entry_t e;
        int unsigned i;
        i      = int'(idx);
        e.cpu  = FREQ_W'(TBL_BASE_KHZ + TBL_INC_KHZ * i);
        e.div  = (i < TBL_SPLIT) ? DIV_W'(TBL_DIV_LO) : DIV_W'(TBL_DIV_HI);
        e.step = FREQ_W'(ALPHA_KHZ / ((i < TBL_SPLIT) ? TBL_DIV_LO : TBL_DIV_HI));
        return e;
    endfunction

endpackage

// File: rtl/fsel_div.sv
module fsel_div
    import cpu_freq_sel_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    r_sh, r_sub;
    logic          ge;

    always_comb begin
        r_sh  = {rem_q, quo_q[W-1]};
        r_sub = r_sh - {1'b0, dvs_q};
        ge    = (r_sh >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dvs_q <= divisor_i;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                rem_q <= ge ? W'(r_sub) : W'(r_sh);
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) done_o <= 1'b1;
            end
        end
    end

    assign quot_o = quo_q;
endmodule

// File: rtl/fsel_calc.sv
module fsel_calc
    import cpu_freq_sel_pkg::*;
#(
    parameter int unsigned VMIN = VCO_MIN_KHZ,
    parameter int unsigned VMAX = VCO_MAX_KHZ,
    parameter int unsigned KPN  = KHZ_PER_N
) (
    input  fsel_req_t         req_i,
    output fsel_res_t         res_o,
    output logic [FREQ_W-1:0] dvd_o,
    output logic [FREQ_W-1:0] dvs_o
);
    localparam int WW = FREQ_W + DIV_W + 2;

    tbl_entry_t       ent;
    logic [DIV_W-1:0] div;
    logic [MAG_W-1:0] mag;
    logic             down, direct, under;
    logic [WW-1:0]    base, offs, cpu_w, vco_w;

    always_comb begin
        ent    = tbl_lookup(req_i.idx);
        div    = req_i.ovr_en ? req_i.ovr_div : ent.div;
        direct = (req_i.mode == MODE_DIRECT);
        mag    = req_i.step[MAG_W-1:0];
        down   = req_i.step[STEP_W-1];
        base   = WW'(ent.cpu);
        offs   = WW'(mag) * WW'(ent.step);
        under  = 1'b0;
        cpu_w  = base;
        if (req_i.mode == MODE_STEP) begin
            if (down) begin
                under = (offs >= base);
                cpu_w = base - offs;
            end else begin
                cpu_w = base + offs;
            end
        end
        vco_w = direct ? WW'(req_i.n) * WW'(KPN) : cpu_w * WW'(div);

        res_o.bad    = (div == '0) || (!direct && under) ||
                       (vco_w < WW'(VMIN)) || (vco_w > WW'(VMAX));
        res_o.direct = direct;
        res_o.cpu    = direct ? '0 : FREQ_W'(cpu_w);
        res_o.vco    = FREQ_W'(vco_w);
        res_o.div    = div;
        res_o.n      = direct ? req_i.n : '0;

        dvd_o = FREQ_W'(vco_w);
        dvs_o = direct ? FREQ_W'(div) : FREQ_W'(KPN);
    end
endmodule

// File: rtl/cpu_freq_sel.sv
module cpu_freq_sel
    import cpu_freq_sel_pkg::*;
#(
    parameter int unsigned VMIN = VCO_MIN_KHZ,
    parameter int unsigned VMAX = VCO_MAX_KHZ,
    parameter int unsigned KPN  = KHZ_PER_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply_i,
    input  logic [1:0]        mode_i,
    input  logic [IDX_W-1:0]  jumper_idx_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic              idx_from_reg_i,
    input  logic [STEP_W-1:0] step_code_i,
    input  logic [N_W-1:0]    loop_n_i,
    input  logic              div_ovr_en_i,
    input  logic [DIV_W-1:0]  div_ovr_i,
    output logic              busy_o,
    output logic              upd_valid_o,
    output logic              cfg_err_o,
    output logic [FREQ_W-1:0] cpu_khz_o,
    output logic [FREQ_W-1:0] vco_khz_o,
    output logic [DIV_W-1:0]  vco_div_o,
    output logic [N_W-1:0]    loop_n_o
);
    fsel_state_e       st_q;
    fsel_req_t         cur_req, req_q;
    fsel_res_t         calc_res, res_q;
    logic [FREQ_W-1:0] dvd, dvs, quot;
    logic              div_start, div_done;

    always_comb begin
        cur_req.mode    = fsel_mode_e'(mode_i);
        cur_req.idx     = idx_from_reg_i ? reg_idx_i : jumper_idx_i;
        cur_req.step    = step_code_i;
        cur_req.n       = loop_n_i;
        cur_req.ovr_en  = div_ovr_en_i;
        cur_req.ovr_div = div_ovr_i;
    end

    fsel_calc #(.VMIN(VMIN), .VMAX(VMAX), .KPN(KPN)) calc_i (
        .req_i (req_q),
        .res_o (calc_res),
        .dvd_o (dvd),
        .dvs_o (dvs)
    );

    assign div_start = (st_q == ST_PREP) && !calc_res.bad;

    fsel_div #(.W(FREQ_W)) div_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (div_start),
        .dividend_i (dvd),
        .divisor_i  (dvs),
        .done_o     (div_done),
        .quot_o     (quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            req_q       <= '0;
            res_q       <= '0;
            cfg_err_o   <= 1'b0;
            upd_valid_o <= 1'b0;
            cpu_khz_o   <= '0;
            vco_khz_o   <= '0;
            vco_div_o   <= '0;
            loop_n_o    <= '0;
        end else begin
            upd_valid_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (apply_i) begin
                        req_q <= cur_req;
                        st_q  <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    res_q <= calc_res;
                    st_q  <= calc_res.bad ? ST_FIN : ST_DIV;
                end
                ST_DIV: begin
                    if (div_done) begin
                        if (res_q.direct) res_q.cpu <= quot;
                        else              res_q.n   <= N_W'(quot);
                        st_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (res_q.bad) begin
                        cfg_err_o <= 1'b1;
                    end else begin
                        cfg_err_o   <= 1'b0;
                        upd_valid_o <= 1'b1;
                        cpu_khz_o   <= res_q.cpu;
                        vco_khz_o   <= res_q.vco;
                        vco_div_o   <= res_q.div;
                        loop_n_o    <= res_q.n;
                    end
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/cpu_freq_sel_chk.sv
module cpu_freq_sel_chk
    import cpu_freq_sel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              apply_i,
    input logic              busy_o,
    input logic              upd_valid_o,
    input logic              cfg_err_o,
    input logic [FREQ_W-1:0] cpu_khz_o,
    input logic [FREQ_W-1:0] vco_khz_o,
    input logic [DIV_W-1:0]  vco_div_o,
    input logic [N_W-1:0]    loop_n_o
);
    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |=> !upd_valid_o);

    // R9
    hold_setting_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid_o |-> ($stable(cpu_khz_o) && $stable(vco_khz_o) &&
                          $stable(vco_div_o) && $stable(loop_n_o)));

    // R8
    vco_legal_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> (vco_khz_o >= FREQ_W'(VCO_MIN_KHZ) &&
                         vco_khz_o <= FREQ_W'(VCO_MAX_KHZ) && vco_div_o != '0));

    // R9
    valid_clears_err_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> !cfg_err_o);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && !busy_o) |=> busy_o);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> !busy_o);

    // R8
    err_at_finish_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_err_o) |-> (!busy_o && $past(busy_o)));
endmodule

bind cpu_freq_sel cpu_freq_sel_chk chk_i (.*);

// File: tb/cpu_freq_sel_tb_top.sv
`timescale 1ns/1ps
module cpu_freq_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        apply_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [4:0]  jumper_idx_i = '0, reg_idx_i = '0;
    logic        idx_from_reg_i = 1'b0;
    logic [7:0]  step_code_i = '0;
    logic [15:0] loop_n_i = '0;
    logic        div_ovr_en_i = 1'b0;
    logic [3:0]  div_ovr_i = '0;
    logic        busy_o, upd_valid_o, cfg_err_o;
    logic [21:0] cpu_khz_o, vco_khz_o;
    logic [3:0]  vco_div_o;
    logic [15:0] loop_n_o;

    always #2 clk = ~clk;

    cpu_freq_sel dut_i (.*);

    int n_run = 0, n_fail = 0, n_valid = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic        use_reg;
        logic [4:0]  jmp;
        logic [4:0]  ridx;
        logic [7:0]  step;
        logic [15:0] n;
        logic        ovr_en;
        logic [3:0]  ovr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 5'd0,  5'd0,  8'h00, 16'd0,     1'b0, 4'd0, 8'd1},  // R1 lowest entry
        '{2'd0, 1'b1, 5'd3,  5'd31, 8'h00, 16'd0,     1'b0, 4'd0, 8'd2},  // R2 register index
        '{2'd0, 1'b0, 5'd9,  5'd30, 8'h00, 16'd0,     1'b0, 4'd0, 8'd2},  // R2 jumper index
        '{2'd1, 1'b0, 5'd5,  5'd0,  8'h0A, 16'd0,     1'b0, 4'd0, 8'd3},  // R3 +10 steps
        '{2'd1, 1'b0, 5'd20, 5'd0,  8'hFF, 16'd0,     1'b0, 4'd0, 8'd3},  // R3 -127 steps
        '{2'd1, 1'b0, 5'd3,  5'd0,  8'h80, 16'd0,     1'b0, 4'd0, 8'd4},  // R4 negative zero
        '{2'd1, 1'b0, 5'd3,  5'd0,  8'h00, 16'd0,     1'b0, 4'd0, 8'd4},  // R4 positive zero
        '{2'd2, 1'b0, 5'd2,  5'd0,  8'h00, 16'd20000, 1'b0, 4'd0, 8'd5},  // R5 direct
        '{2'd2, 1'b0, 5'd2,  5'd0,  8'h00, 16'd10000, 1'b1, 4'd5, 8'd6},  // R6 direct + override
        '{2'd0, 1'b0, 5'd21, 5'd0,  8'h00, 16'd0,     1'b1, 4'd8, 8'd8},  // R8 exactly max
        '{2'd1, 1'b0, 5'd21, 5'd0,  8'h01, 16'd0,     1'b1, 4'd8, 8'd8},  // R8 one step over
        '{2'd0, 1'b0, 5'd0,  5'd0,  8'h00, 16'd0,     1'b1, 4'd2, 8'd8},  // R8 below min
        '{2'd2, 1'b0, 5'd0,  5'd0,  8'h00, 16'd50000, 1'b0, 4'd0, 8'd8},  // R8 direct too high
        '{2'd0, 1'b0, 5'd4,  5'd0,  8'h00, 16'd0,     1'b1, 4'd0, 8'd8},  // R8 zero divider
        '{2'd3, 1'b0, 5'd7,  5'd0,  8'h05, 16'd999,   1'b0, 4'd0, 8'd7},  // R7 mode 3
        '{2'd1, 1'b1, 5'd0,  5'd12, 8'h85, 16'd0,     1'b1, 4'd3, 8'd6}   // R6 step + override
    };

    typedef struct {
        longint cpu, vco, dv, n;
        bit     bad;
    } exp_t;

    // Model written from the requirement text.
    function automatic exp_t model(vec_t v);
        exp_t e;
        longint idx, pc, pd, ps, m;
        idx = v.use_reg ? v.ridx : v.jmp;
        pc  = 66000 + 4000 * idx;
        pd  = (idx < 16) ? 4 : 6;
        ps  = 1790 / pd;
        e.dv = v.ovr_en ? v.ovr : pd;
        if (v.mode == 2'd2) begin
            e.vco = v.n * 28;
            e.cpu = (e.dv != 0) ? e.vco / e.dv : 0;
            e.n   = v.n;
            e.bad = 0;
        end else begin
            e.cpu = pc;
            if (v.mode == 2'd1) begin
                m = v.step[6:0];
                e.cpu = v.step[7] ? pc - m * ps : pc + m * ps;
            end
            e.vco = e.cpu * e.dv;
            e.n   = e.vco / 28;
            e.bad = (e.cpu <= 0);
        end
        e.bad = e.bad || (e.dv == 0) || (e.vco < 200000) || (e.vco > 1200000);
        return e;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic drive(vec_t v);
        mode_i = v.mode; idx_from_reg_i = v.use_reg; jumper_idx_i = v.jmp;
        reg_idx_i = v.ridx; step_code_i = v.step; loop_n_i = v.n;
        div_ovr_en_i = v.ovr_en; div_ovr_i = v.ovr;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    always @(negedge clk) if (!rst && upd_valid_o) n_valid++;

    longint kc = 0, kv = 0, kd = 0, kn = 0;

    task automatic check_result(exp_t e, string tag);
        if (e.bad) begin
            chk(cfg_err_o == 1'b1, {tag, " err"}, cfg_err_o, 1);
            chk(upd_valid_o == 1'b0, {tag, " valid"}, upd_valid_o, 0);
        end else begin
            kc = e.cpu; kv = e.vco; kd = e.dv; kn = e.n;
            chk(cfg_err_o == 1'b0, {tag, " err"}, cfg_err_o, 0);
            chk(upd_valid_o == 1'b1, {tag, " valid"}, upd_valid_o, 1);
        end
        chk(cpu_khz_o == kc, {tag, " cpu"}, cpu_khz_o, kc);
        chk(vco_khz_o == kv, {tag, " vco"}, vco_khz_o, kv);
        chk(vco_div_o == kd, {tag, " div"}, vco_div_o, kd);
        chk(loop_n_o == kn, {tag, " n"}, loop_n_o, kn);
    endtask

    task automatic run_vec(vec_t v);
        exp_t e;
        e = model(v);
        @(negedge clk);
        drive(v);
        apply_i = 1'b1;
        @(negedge clk);
        apply_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy rise", busy_o, 1);
        wait_idle();
        check_result(e, $sformatf("R%0d", v.req));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog expired actual=busy expected=idle");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int vb;
        vec_t a, b;
        exp_t ea;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({busy_o, upd_valid_o, cfg_err_o} == 3'b000, "R11 flags", {busy_o, upd_valid_o, cfg_err_o}, 0);
        chk(cpu_khz_o == 0 && vco_khz_o == 0, "R11 freq", cpu_khz_o, 0);
        chk(vco_div_o == 0 && loop_n_o == 0, "R11 div/n", loop_n_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && upd_valid_o == 1'b0, "R11 after release", busy_o, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: strobe during busy is ignored
        a = VECS[0];
        b = VECS[1];
        ea = model(a);
        @(negedge clk);
        vb = n_valid;
        drive(a);
        apply_i = 1'b1;
        @(negedge clk);
        drive(b);
        @(negedge clk);
        apply_i = 1'b0;
        wait_idle();
        check_result(ea, "R10 busy strobe");
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b0, "R10 no restart", busy_o, 0);
        chk(n_valid == vb + 1, "R10 pulse count", n_valid, vb + 1);
        // R9 outputs hold with no further request
        chk(cpu_khz_o == ea.cpu, "R9 hold cpu", cpu_khz_o, ea.cpu);
        chk(upd_valid_o == 1'b0, "R9 pulse width", upd_valid_o, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule